// File: doc/BRIEF.md
# Flash Page Programming Sequencer

This block manages writes into an on-chip flash model. Software first fills a page-sized staging buffer (the column latches) one byte at a time. Any subset of positions may be filled, from a single byte up to a whole page. Software then issues a two-step launch command on a control port. The first step writes key 5. The second step, which must be the very next control write, writes key A. The control write that carries key A also supplies a target selector and a page number.

On a valid launch the block enters a busy phase. The busy phase lasts a fixed number of clock cycles, set by a parameter, and stands in for the program time of the cells. For the whole phase the block asserts a stall to the processor, and reads of the array return zero because code cannot be fetched from it. At the last busy edge, every latch position loaded since the previous launch is copied into the chosen target. The stall then drops on its own.

There are three targets: a page of the user code array, the single extra row, and the hardware security byte. The security byte only ever shows its lower four bits to software.

Top module: `flash_page_prog`

## Requirements
- R1: A control write with key 5, followed directly by a control write with key A (the next control write, with any number of idle cycles in between), launches programming. `busy` is 1 in the cycle after the edge that samples the key-A write. A key-5 write always arms the sequence, so the pattern 5, 5, A also launches.
- R2: A control write with any key other than 5 or A, made after a 5, clears the arming. A key-A write that does not directly follow a 5 launches nothing.
- R3: `ctl_mode` on the key-A write selects the target. 0 is the user array page `ctl_page`. 1 is the extra row. 2 is the security byte, which takes latch position 0. 3 is reserved: the key-A write completes the sequence but starts no programming.
- R4: A load (`ld_we`) stores `ld_data` at latch position `ld_idx` and marks that position. Only marked positions are written to the target. Unmarked target bytes keep their value. Anywhere from 1 to PAGE_BYTES positions may be loaded.
- R5: `busy` stays high for exactly PROG_CYCLES cycles and then falls by itself. `cpu_stall` equals `busy`. The target holds the new data from the cycle in which `busy` is low again.
- R6: While `busy` is high, `rd_data` reads 0x00 for every read mode.
- R7: A read with `rd_mode` = 2 returns the security byte with bits 7:4 forced to zero.
- R8: All load marks are cleared when programming completes. A later launch with no new loads leaves every target unchanged.
- R9: Control writes and latch loads made while `busy` is high are ignored. They neither start a new operation nor mark a position.
- R10: After reset, `busy` and `cpu_stall` are 0, every user-array and extra-row byte reads 0xFF, the security read returns 0x0F, and no position is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Load one latch byte |
| ld_idx | input | IDX_W | Latch position to load |
| ld_data | input | 8 | Byte to load |
| ctl_we | input | 1 | Control write strobe |
| ctl_key | input | 4 | Launch key field (5 arms, A launches) |
| ctl_mode | input | 2 | Target selector: 0 user, 1 extra row, 2 security, 3 reserved |
| ctl_page | input | PG_W | User array page for the launch |
| rd_mode | input | 2 | Read space, same encoding as ctl_mode |
| rd_addr | input | PG_W+IDX_W | Read address {page, byte}; only the byte part is used for the extra row |
| rd_data | output | 8 | Read data (combinational) |
| busy | output | 1 | Programming in progress |
| cpu_stall | output | 1 | Holds the processor idle during programming |

## Verification
The bench breaks the unlock pattern in several ways: an alien key between the 5 and the A, a lone A, the reserved target, and a doubled 5. A design with a loose sequencer would start programming on one of these, and one with a strict sequencer would refuse the 5, 5, A case. It fires launch keys and loads in the middle of a busy phase. A design that let them through would restart the busy count or program a byte that was never loaded in an idle window. It relaunches with no fresh loads to catch marks that survive completion, programs partial and full pages so that any spill into unmarked bytes shows up in a full sweep of every address, and checks that reads of the security byte hide its upper nibble.

// File: rtl/fpp_pkg.sv
`timescale 1ns/1ps
package fpp_pkg;
   typedef enum logic [1:0] {
      TGT_USER = 2'd0,
      TGT_XROW = 2'd1,
      TGT_SEC  = 2'd2,
      TGT_NONE = 2'd3
   } tgt_e;

   localparam logic [3:0] KEY_ARM = 4'h5;
   localparam logic [3:0] KEY_GO  = 4'hA;
   localparam logic [7:0] ERASED  = 8'hFF;
   localparam int         SEC_VIS = 4;
endpackage

// File: rtl/fpp_unlock.sv
`timescale 1ns/1ps
module fpp_unlock
   import fpp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [3:0] ctl_key,
   input  logic [1:0] ctl_mode,
   input  logic       busy,
   output logic       launch
);
   logic armed_q;
   logic accept;

   always_comb begin
      accept = ctl_we && !busy;
      launch = accept && armed_q && (ctl_key == KEY_GO) && (ctl_mode != TGT_NONE);
   end

   // every accepted write re-evaluates the arm: only key 5 leaves it set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (accept)
         armed_q <= (ctl_key == KEY_ARM);
   end
endmodule

// File: rtl/fpp_latch.sv
`timescale 1ns/1ps
module fpp_latch
   import fpp_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_we,
   input  logic [IDX_W-1:0]             ld_idx,
   input  logic [7:0]                   ld_data,
   input  logic                         busy,
   input  logic                         clear,
   output logic [PAGE_BYTES-1:0][7:0]   lat_data,
   output logic [PAGE_BYTES-1:0]        lat_mark
);
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
      logic [7:0] byte_q;
      logic       mark_q;
      logic       hit;

      assign hit = ld_we && !busy && (ld_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= ERASED;
            mark_q <= 1'b0;
         end else if (clear) begin
            mark_q <= 1'b0;
         end else if (hit) begin
            byte_q <= ld_data;
            mark_q <= 1'b1;
         end
      end

      assign lat_data[g] = byte_q;
      assign lat_mark[g] = mark_q;
   end
endmodule

// File: rtl/fpp_timer.sv
`timescale 1ns/1ps
module fpp_timer #(
   parameter int PROG_CYCLES = 24,
   localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic done
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end else if (busy_q) begin
         if (cnt_q == '0)
            busy_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/fpp_store.sv
`timescale 1ns/1ps
module fpp_store
   import fpp_pkg::*;
#(
   parameter int PAGE_BYTES = 16,
   parameter int PAGES      = 8,
   localparam int IDX_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = $clog2(PAGES),
   localparam int ADDR_W    = IDX_W + PG_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        done,
   input  tgt_e                        tgt,
   input  logic [PG_W-1:0]             page,
   input  logic [PAGE_BYTES-1:0][7:0]  lat_data,
   input  logic [PAGE_BYTES-1:0]       lat_mark,
   input  logic                        busy,
   input  logic [1:0]                  rd_mode,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [7:0]                  rd_data
);
   logic [PAGES-1:0][PAGE_BYTES-1:0][7:0] umem;
   logic [PAGE_BYTES-1:0][7:0]            xrow_q;
   logic [SEC_VIS-1:0]                    sec_q;

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      logic [PAGE_BYTES-1:0][7:0] pg_q;
      logic                       sel;

      assign sel = done && (tgt == TGT_USER) && (page == PG_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int b = 0; b < PAGE_BYTES; b++) pg_q[b] <= ERASED;
         end else if (sel) begin
            for (int b = 0; b < PAGE_BYTES; b++)
               if (lat_mark[b]) pg_q[b] <= lat_data[b];
         end
      end

      assign umem[p] = pg_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < PAGE_BYTES; b++) xrow_q[b] <= ERASED;
      end else if (done && tgt == TGT_XROW) begin
         for (int b = 0; b < PAGE_BYTES; b++)
            if (lat_mark[b]) xrow_q[b] <= lat_data[b];
      end
   end

   // only the visible nibble is kept; the upper bits never reach software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sec_q <= ERASED[SEC_VIS-1:0];
      else if (done && tgt == TGT_SEC && lat_mark[0])
         sec_q <= lat_data[0][SEC_VIS-1:0];
   end

   logic [PG_W-1:0]  r_pg;
   logic [IDX_W-1:0] r_ix;

   always_comb begin
      r_pg = rd_addr[ADDR_W-1:IDX_W];
      r_ix = rd_addr[IDX_W-1:0];
      if (busy) begin
         rd_data = 8'h00;
      end else begin
         case (rd_mode)
            2'd0:    rd_data = umem[r_pg][r_ix];
            2'd1:    rd_data = xrow_q[r_ix];
            2'd2:    rd_data = {{(8-SEC_VIS){1'b0}}, sec_q};
            default: rd_data = 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/flash_page_prog.sv
`timescale 1ns/1ps
module flash_page_prog
   import fpp_pkg::*;
#(
   parameter int PAGE_BYTES  = 16,
   parameter int PAGES       = 8,
   parameter int PROG_CYCLES = 24,
   localparam int IDX_W      = $clog2(PAGE_BYTES),
   localparam int PG_W       = $clog2(PAGES),
   localparam int ADDR_W     = IDX_W + PG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [7:0]        ld_data,
   input  logic              ctl_we,
   input  logic [3:0]        ctl_key,
   input  logic [1:0]        ctl_mode,
   input  logic [PG_W-1:0]   ctl_page,
   input  logic [1:0]        rd_mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              cpu_stall
);
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page_bytes
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
      $error("PAGES must be a power of two, at least 2");
   end
   if (PROG_CYCLES < 1) begin : g_bad_cycles
      $error("PROG_CYCLES must be at least 1");
   end

   logic                       launch;
   logic                       done;
   logic                       busy_w;
   logic [PAGE_BYTES-1:0][7:0] lat_data;
   logic [PAGE_BYTES-1:0]      lat_mark;
   tgt_e                       tgt_q;
   logic [PG_W-1:0]            page_q;

   fpp_unlock u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_key  (ctl_key),
      .ctl_mode (ctl_mode),
      .busy     (busy_w),
      .launch   (launch)
   );

   fpp_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .busy   (busy_w),
      .done   (done)
   );

   fpp_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (ld_we),
      .ld_idx   (ld_idx),
      .ld_data  (ld_data),
      .busy     (busy_w),
      .clear    (done),
      .lat_data (lat_data),
      .lat_mark (lat_mark)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= TGT_NONE;
         page_q <= '0;
      end else if (launch) begin
         tgt_q  <= tgt_e'(ctl_mode);
         page_q <= ctl_page;
      end
   end

   fpp_store #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .tgt      (tgt_q),
      .page     (page_q),
      .lat_data (lat_data),
      .lat_mark (lat_mark),
      .busy     (busy_w),
      .rd_mode  (rd_mode),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   assign busy      = busy_w;
   assign cpu_stall = busy_w;
endmodule

// File: rtl/fpp_check.sv
`timescale 1ns/1ps
module fpp_check #(
   parameter int PROG_CYCLES = 24
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_we,
   input logic [3:0] ctl_key,
   input logic [1:0] ctl_mode,
   input logic [1:0] rd_mode,
   input logic [7:0] rd_data,
   input logic       busy
);
   logic        prev_arm;
   logic [31:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_arm <= 1'b0;
      else if (ctl_we && !busy)
         prev_arm <= (ctl_key == 4'h5);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= '0;
      else if (busy)
         run <= run + 1;
      else
         run <= '0;
   end

   p_launch_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(ctl_we) && $past(ctl_key) == 4'hA && $past(prev_arm)));

   p_lone_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_we && ctl_key == 4'hA && !prev_arm) |=> !busy);

   p_reserved_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_we && ctl_mode == 2'd3) |=> !busy);

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == PROG_CYCLES));

   p_read_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_data == 8'h00));

   p_sec_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode == 2'd2) |-> (rd_data[7:4] == 4'h0));

   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run < PROG_CYCLES - 1) |=> busy);
endmodule

bind flash_page_prog fpp_check #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_we   (ctl_we),
   .ctl_key  (ctl_key),
   .ctl_mode (ctl_mode),
   .rd_mode  (rd_mode),
   .rd_data  (rd_data),
   .busy     (busy)
);

// File: tb/sim_flash_page_prog.sv
`timescale 1ns/1ps
module sim_flash_page_prog;
   localparam int PB = 16;
   localparam int NP = 8;
   localparam int PC = 24;
   localparam int IW = $clog2(PB);
   localparam int PW = $clog2(NP);
   localparam int AW = IW + PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_we = 1'b0;
   logic [IW-1:0] ld_idx = '0;
   logic [7:0]    ld_data = '0;
   logic          ctl_we = 1'b0;
   logic [3:0]    ctl_key = '0;
   logic [1:0]    ctl_mode = '0;
   logic [PW-1:0] ctl_page = '0;
   logic [1:0]    rd_mode = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy;
   logic          cpu_stall;

   flash_page_prog #(.PAGE_BYTES(PB), .PAGES(NP), .PROG_CYCLES(PC)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
      .ctl_we(ctl_we), .ctl_key(ctl_key), .ctl_mode(ctl_mode), .ctl_page(ctl_page),
      .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .cpu_stall(cpu_stall)
   );

   always #2.5 clk = ~clk;

   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   logic [7:0] m_user [NP*PB];
   logic [7:0] m_x    [PB];
   logic [7:0] m_sec;
   logic [7:0] m_lat  [PB];
   bit         m_mark [PB];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(int mode, int addr);
      case (mode)
         0:       return m_user[addr];
         1:       return m_x[addr % PB];
         2:       return {4'h0, m_sec[3:0]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic load(int idx, logic [7:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_idx = IW'(idx); ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
      m_lat[idx] = d;
      m_mark[idx] = 1'b1;
   endtask

   task automatic ctl(logic [3:0] key, int mode, int page);
      @(negedge clk);
      ctl_we = 1'b1; ctl_key = key; ctl_mode = 2'(mode); ctl_page = PW'(page);
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic model_prog(int mode, int page);
      for (int b = 0; b < PB; b++) begin
         if (m_mark[b]) begin
            if (mode == 0) m_user[page*PB + b] = m_lat[b];
            else if (mode == 1) m_x[b] = m_lat[b];
            else if (mode == 2 && b == 0) m_sec = m_lat[0];
         end
         m_mark[b] = 1'b0;
      end
   endtask

   // called at the negedge right after the launch edge
   task automatic wait_prog(int mode, int page, bit inject);
      rd_mode = 2'd0; rd_addr = '0;
      for (int k = 0; k < PC; k++) begin
         chk("R5 busy held", busy, 1);
         if (k == 0) chk("R5 stall", cpu_stall, 1);
         if (k == 1) chk("R6 read blocked", rd_data, 8'h00);
         if (inject && k == 2) begin
            ld_we = 1'b1; ld_idx = IW'(2); ld_data = 8'h77;
            ctl_we = 1'b1; ctl_key = 4'h5; ctl_mode = 2'd0; ctl_page = '0;
         end
         if (inject && k == 3) begin
            ld_we = 1'b0; ctl_key = 4'hA;
         end
         if (inject && k == 4) ctl_we = 1'b0;
         @(negedge clk);
      end
      chk("R5 busy released", busy, 0);
      chk("R5 stall released", cpu_stall, 0);
      model_prog(mode, page);
   endtask

   task automatic sweep(string req);
      for (int m = 0; m < 3; m++) begin
         int lim;
         lim = (m == 0) ? NP*PB : (m == 1) ? PB : 1;
         for (int a = 0; a < lim; a++) begin
            rd_mode = 2'(m); rd_addr = AW'(a);
            #0.1;
            chk(req, rd_data, exp_read(m, a));
         end
      end
   endtask

   task automatic launch(int mode, int page);
      ctl(4'h5, mode, page);
      ctl(4'hA, mode, page);
      chk("R1 launch", busy, 1);
      wait_prog(mode, page, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < NP*PB; i++) m_user[i] = 8'hFF;
      for (int i = 0; i < PB; i++) begin m_x[i] = 8'hFF; m_lat[i] = 8'hFF; m_mark[i] = 1'b0; end
      m_sec = 8'hFF;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      chk("R10 busy at reset", busy, 0);
      chk("R10 stall at reset", cpu_stall, 0);
      sweep("R10 erased contents");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 and R4: single byte into page 2
      load(3, 8'h3C);
      launch(0, 2);
      sweep("R4 single byte");

      // R2: broken sequence and lone A
      load(0, 8'h11);
      ctl(4'h5, 0, 1); ctl(4'h3, 0, 1); ctl(4'hA, 0, 1);
      chk("R2 broken sequence", busy, 0);
      ctl(4'hA, 0, 1);
      chk("R2 lone A", busy, 0);

      // R3: reserved target does not start
      ctl(4'h5, 3, 0); ctl(4'hA, 3, 0);
      chk("R3 reserved target", busy, 0);
      sweep("R3 reserved no change");

      // R1: 5,5,A launches into the extra row
      ctl(4'h5, 1, 0); ctl(4'h5, 1, 0); ctl(4'hA, 1, 0);
      chk("R1 double arm", busy, 1);
      wait_prog(1, 0, 1'b0);
      sweep("R3 extra row");

      // R8: relaunch with nothing loaded
      launch(0, 5);
      sweep("R8 marks cleared");

      // R7: security byte
      load(0, 8'hA3);
      launch(2, 0);
      rd_mode = 2'd2; #0.1;
      chk("R7 security nibble", rd_data, 8'h03);
      sweep("R7 security");

      // R9: traffic during busy
      load(1, 8'h55);
      ctl(4'h5, 0, 0); ctl(4'hA, 0, 0);
      chk("R1 launch", busy, 1);
      wait_prog(0, 0, 1'b1);
      @(negedge clk);
      chk("R9 no relaunch", busy, 0);
      sweep("R9 busy traffic");
      launch(0, 0);
      sweep("R9 busy load ignored");

      // R4: full page
      for (int b = 0; b < PB; b++) load(b, 8'(b * 17 + 1));
      launch(0, NP - 1);
      sweep("R4 full page");

      // constrained random
      for (int it = 0; it < 12; it++) begin
         int n, md, pg;
         n  = 1 + int'($urandom_range(PB - 1));
         md = int'($urandom_range(2));
         pg = int'($urandom_range(NP - 1));
         for (int j = 0; j < n; j++) load(int'($urandom_range(PB - 1)), 8'($urandom));
         launch(md, pg);
         sweep("R4 random program");
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule